// File: doc/BRIEF.md
# Micro-op Execution Port Dispatcher

This block sits between a window of ready micro-ops and eight execution ports. In every cycle it looks at up to eight window entries. Each entry has a valid bit, a class code, a hardware-thread bit and an age rank. The block grants each port at most one micro-op, and it chooses by class, because the ports support different classes. The grant vector goes back to the window in the same cycle, so the granted entries can be removed before the next clock edge. In the following cycle each port receives a unit enable together with the index, class and thread of the micro-op it executes. A port with nothing to execute keeps its enable low, so its unit can be gated off.

The ports do not all support the same classes, so the order of allocation matters. Ports are filled in a fixed sequence. Each port takes the oldest entry that it can accept and that no earlier port in the sequence has taken. Two exceptions apply: the integer/branch port serves branches first, and the dedicated store-address port is filled before the two shared load/store-address ports. For every port the block keeps a short in-flight pipeline. This pipeline produces a completion pulse a fixed number of cycles after the grant, according to the class latency. The same pipeline holds a port while a fused multiply-add is in flight, and it refuses a grant that would complete in a cycle when that port already completes another micro-op.

Top module: `uop_port_dispatch`

## Requirements
- R1: Each window entry is granted to at most one port per cycle, each port receives at most one micro-op per cycle, and only valid entries are granted.
- R2: Class codes are ALU=0, branch=1, FMA=2, load=3, store-address=4, store-data=5. The port capabilities are: port 0 takes ALU, branch and FMA; port 1 takes ALU and FMA; ports 2 and 3 take load and store-address; port 4 takes store-data; port 5 takes ALU; port 6 takes ALU and branch; port 7 takes store-address only.
- R3: Ports are allocated in the order 7, 4, 2, 3, 6, 0, 1, 5. Each port takes the entry with the lowest age value among the valid, not yet granted entries that it accepts and that its in-flight state allows.
- R4: Port 6 grants the oldest eligible branch whenever any branch is eligible for it, and otherwise the oldest ALU micro-op. A second branch in the same cycle goes to port 0.
- R5: A store-address micro-op goes to port 7 when that port is free. Otherwise it competes by age on port 2 and then on port 3.
- R6: After a port is granted an FMA, it grants nothing for the next FMA_LAT-1 cycles.
- R7: A micro-op granted in cycle t produces a completion pulse on its port in cycle t+L, carrying its window index and thread. L is FMA_LAT for FMA, LD_LAT for load, and 1 for all other classes.
- R8: A port does not grant a micro-op whose completion would fall in a cycle in which that port already has a completion scheduled.
- R9: In the cycle after a grant, the port's enable is high and it carries the granted index, class and thread. A port that was granted nothing has its enable low.
- R10: While reset is active and in the first cycle after it, every port enable and every completion pulse is low, and the in-flight state is empty.
- R11: Micro-ops from both threads compete only by age, and the thread bit travels unchanged to the port outputs and to the completion pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_vld | input | 8 | Window entry valid bits |
| win_cls | input | 8x3 | Window entry class codes |
| win_tid | input | 8 | Window entry thread bits |
| win_age | input | 8xAGE_W | Window entry age rank, lower is older |
| grant | output | 8 | Entries granted this cycle (combinational) |
| port_en | output | 8 | Per-port unit enable, one cycle after grant |
| port_idx | output | 8x3 | Window index issued to each port |
| port_cls | output | 8x3 | Class issued to each port |
| port_tid | output | 8 | Thread issued to each port |
| cmp_vld | output | 8 | Per-port completion pulse |
| cmp_idx | output | 8x3 | Window index of the completing micro-op |
| cmp_tid | output | 8 | Thread of the completing micro-op |

## Verification
The assertions rely on three conditions on the inputs:
- the valid window entries carry distinct age values;
- class codes stay within 0 to 5;
- FMA_LAT is at least 2.

They also rely on the caller removing granted entries before the next cycle. The bench keeps within these conditions in three ways. It drives each age as the rank of the entry's insertion order among the valid entries. It draws classes only from the six defined codes. It clears every granted entry from its window copy before it refills any slot.

// File: rtl/upd_pkg.sv
package upd_pkg;

    localparam int NUM_ENT   = 8;
    localparam int ENT_W     = $clog2(NUM_ENT);
    localparam int NUM_PORTS = 8;
    localparam int NUM_CLS   = 6;
    localparam int CLS_W     = 3;

    typedef enum logic [CLS_W-1:0] {
        CLS_ALU = 3'd0,
        CLS_BR  = 3'd1,
        CLS_FMA = 3'd2,
        CLS_LD  = 3'd3,
        CLS_STA = 3'd4,
        CLS_STD = 3'd5
    } uop_cls_e;

    // One micro-op handed to a port
    typedef struct packed {
        logic             vld;
        logic [ENT_W-1:0] idx;
        logic [CLS_W-1:0] cls;
        logic             tid;
    } issue_t;

    // One slot of a port's in-flight pipeline
    typedef struct packed {
        logic             vld;
        logic             fma;
        logic             tid;
        logic [ENT_W-1:0] idx;
    } inflight_t;

    // Capability mask per port, bit c set when class c is accepted
    function automatic logic [NUM_CLS-1:0] port_caps(int p);
        case (p)
            0:       return 6'b000111;
            1:       return 6'b000101;
            2, 3:    return 6'b011000;
            4:       return 6'b100000;
            5:       return 6'b000001;
            6:       return 6'b000011;
            7:       return 6'b010000;
            default: return 6'b000000;
        endcase
    endfunction

    // Classes a port serves ahead of its other classes
    function automatic logic [NUM_CLS-1:0] port_pref(int p);
        return (p == 6) ? 6'b000010 : 6'b000000;
    endfunction

    // Allocation sequence: stage s serves the returned port
    function automatic int steer_port(int s);
        case (s)
            0:       return 7;
            1:       return 4;
            2:       return 2;
            3:       return 3;
            4:       return 6;
            5:       return 0;
            6:       return 1;
            default: return 5;
        endcase
    endfunction

    function automatic int cls_lat(logic [CLS_W-1:0] c, int fma_lat, int ld_lat);
        if (c == CLS_FMA) return fma_lat;
        if (c == CLS_LD)  return ld_lat;
        return 1;
    endfunction

    function automatic logic [NUM_CLS-1:0] cls_onehot(logic [CLS_W-1:0] c);
        return NUM_CLS'(1) << c;
    endfunction

endpackage

// File: rtl/upd_oldest.sv
module upd_oldest #(
    parameter int N     = 8,
    parameter int AGE_W = 4
) (
    input  logic [N-1:0]            elig,
    input  logic [N-1:0][AGE_W-1:0] age,
    output logic                    found,
    output logic [$clog2(N)-1:0]    idx
);
    localparam int IW = $clog2(N);

    logic [AGE_W-1:0] best;

    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (elig[i] && (!found || age[i] < best)) begin
                found = 1'b1;
                idx   = IW'(i);
                best  = age[i];
            end
        end
    end

endmodule

// File: rtl/upd_steer.sv
module upd_steer
    import upd_pkg::*;
#(
    parameter int AGE_W = 4
) (
    input  logic [NUM_ENT-1:0]                ent_vld,
    input  logic [NUM_ENT-1:0][CLS_W-1:0]     ent_cls,
    input  logic [NUM_ENT-1:0]                ent_tid,
    input  logic [NUM_ENT-1:0][AGE_W-1:0]     ent_age,
    input  logic [NUM_PORTS-1:0][NUM_CLS-1:0] port_ok,
    output issue_t [NUM_PORTS-1:0]            iss,
    output logic [NUM_ENT-1:0]                ent_gnt
);

    // taken[s] holds the entries claimed by stages before s
    logic [NUM_PORTS:0][NUM_ENT-1:0] taken;
    assign taken[0] = '0;

    for (genvar s = 0; s < NUM_PORTS; s++) begin : g_stage
        localparam int                P    = steer_port(s);
        localparam logic [NUM_CLS-1:0] CAPS = port_caps(P);
        localparam logic [NUM_CLS-1:0] PREF = port_pref(P);

        logic [NUM_ENT-1:0] elig;
        logic [NUM_ENT-1:0] elig_pref;
        logic [NUM_ENT-1:0] sel;
        logic               found;
        logic [ENT_W-1:0]   pidx;

        always_comb begin
            for (int i = 0; i < NUM_ENT; i++) begin
                elig[i]      = ent_vld[i] && !taken[s][i] &&
                               (|(cls_onehot(ent_cls[i]) & CAPS & port_ok[P]));
                elig_pref[i] = elig[i] && (|(cls_onehot(ent_cls[i]) & PREF));
            end
            sel = (|elig_pref) ? elig_pref : elig;
        end

        upd_oldest #(.N(NUM_ENT), .AGE_W(AGE_W)) u_pick (
            .elig  (sel),
            .age   (ent_age),
            .found (found),
            .idx   (pidx)
        );

        assign iss[P] = '{vld: found, idx: pidx, cls: ent_cls[pidx], tid: ent_tid[pidx]};
        assign taken[s+1] = taken[s] | (found ? (NUM_ENT'(1) << pidx) : '0);
    end

    assign ent_gnt = taken[NUM_PORTS];

endmodule

// File: rtl/upd_track.sv
module upd_track
    import upd_pkg::*;
#(
    parameter int FMA_LAT = 5,
    parameter int LD_LAT  = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  issue_t             iss,
    output logic [NUM_CLS-1:0] cls_ok,
    output inflight_t          cmp
);
    localparam int MAX_LAT = (FMA_LAT > LD_LAT) ? FMA_LAT : LD_LAT;

    // pipe[k] completes k cycles from now
    inflight_t pipe [MAX_LAT];
    logic      busy;
    int        ins_lat;

    always_comb begin
        busy = 1'b0;
        for (int k = 1; k < MAX_LAT; k++) begin
            busy = busy | (pipe[k].vld && pipe[k].fma);
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_CLS; c++) begin
            int   lat;
            logic occ;
            lat = cls_lat(CLS_W'(c), FMA_LAT, LD_LAT);
            occ = 1'b0;
            for (int k = 0; k < MAX_LAT; k++) begin
                if (k == lat) occ = pipe[k].vld;
            end
            cls_ok[c] = !busy && !occ;
        end
    end

    assign ins_lat = cls_lat(iss.cls, FMA_LAT, LD_LAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < MAX_LAT; k++) pipe[k] <= '0;
        end else begin
            for (int k = 0; k < MAX_LAT - 1; k++) pipe[k] <= pipe[k+1];
            pipe[MAX_LAT-1] <= '0;
            if (iss.vld) begin
                for (int k = 0; k < MAX_LAT; k++) begin
                    if (k == ins_lat - 1) begin
                        pipe[k] <= '{vld: 1'b1, fma: (iss.cls == CLS_FMA),
                                     tid: iss.tid, idx: iss.idx};
                    end
                end
            end
        end
    end

    assign cmp = pipe[0];

    AST_WB_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
        iss.vld |-> (|(cls_onehot(iss.cls) & cls_ok)));  // R8

    AST_FMA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (iss.vld && iss.cls == CLS_FMA) |=> !iss.vld);  // R6

    AST_UNIT_LAT_CMP: assert property (@(posedge clk) disable iff (rst)
        (iss.vld && ins_lat == 1) |=> (cmp.vld && cmp.idx == $past(iss.idx)));  // R7

endmodule

// File: rtl/uop_port_dispatch.sv
module uop_port_dispatch
    import upd_pkg::*;
#(
    parameter int AGE_W   = 4,
    parameter int FMA_LAT = 5,
    parameter int LD_LAT  = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [NUM_ENT-1:0]                win_vld,
    input  logic [NUM_ENT-1:0][CLS_W-1:0]     win_cls,
    input  logic [NUM_ENT-1:0]                win_tid,
    input  logic [NUM_ENT-1:0][AGE_W-1:0]     win_age,
    output logic [NUM_ENT-1:0]                grant,
    output logic [NUM_PORTS-1:0]              port_en,
    output logic [NUM_PORTS-1:0][ENT_W-1:0]   port_idx,
    output logic [NUM_PORTS-1:0][CLS_W-1:0]   port_cls,
    output logic [NUM_PORTS-1:0]              port_tid,
    output logic [NUM_PORTS-1:0]              cmp_vld,
    output logic [NUM_PORTS-1:0][ENT_W-1:0]   cmp_idx,
    output logic [NUM_PORTS-1:0]              cmp_tid
);

    issue_t [NUM_PORTS-1:0]            iss;
    logic   [NUM_PORTS-1:0][NUM_CLS-1:0] port_ok;

    upd_steer #(.AGE_W(AGE_W)) u_steer (
        .ent_vld (win_vld),
        .ent_cls (win_cls),
        .ent_tid (win_tid),
        .ent_age (win_age),
        .port_ok (port_ok),
        .iss     (iss),
        .ent_gnt (grant)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        inflight_t cmp;

        upd_track #(.FMA_LAT(FMA_LAT), .LD_LAT(LD_LAT)) u_track (
            .clk    (clk),
            .rst    (rst),
            .iss    (iss[p]),
            .cls_ok (port_ok[p]),
            .cmp    (cmp)
        );

        assign cmp_vld[p] = cmp.vld;
        assign cmp_idx[p] = cmp.idx;
        assign cmp_tid[p] = cmp.tid;

        always_ff @(posedge clk) begin
            if (rst) begin
                port_en[p]  <= 1'b0;
                port_idx[p] <= '0;
                port_cls[p] <= '0;
                port_tid[p] <= 1'b0;
            end else begin
                port_en[p]  <= iss[p].vld;
                port_idx[p] <= iss[p].idx;
                port_cls[p] <= iss[p].cls;
                port_tid[p] <= iss[p].tid;
            end
        end

        AST_PORT_CAPABLE: assert property (@(posedge clk) disable iff (rst)
            port_en[p] |-> (|(port_caps(p) & cls_onehot(port_cls[p]))));  // R2
    end

    AST_GRANT_VALID: assert property (@(posedge clk) disable iff (rst)
        (grant & ~win_vld) == '0);  // R1

    AST_GRANT_COUNT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(port_en) == $countones($past(grant))));  // R1

    AST_IDLE_GATED: assert property (@(posedge clk) disable iff (rst)
        !(|win_vld) |=> (port_en == '0));  // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (port_en == '0 && cmp_vld == '0));  // R10

endmodule

// File: tb/uop_port_dispatch_tb.sv
module uop_port_dispatch_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AGE_W      = 4;
    localparam int FMA_LAT    = 5;
    localparam int LD_LAT     = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [7:0]       win_vld = '0;
    logic [7:0][2:0]  win_cls = '0;
    logic [7:0]       win_tid = '0;
    logic [7:0][AGE_W-1:0] win_age = '0;
    logic [7:0]       grant;
    logic [7:0]       port_en;
    logic [7:0][2:0]  port_idx;
    logic [7:0][2:0]  port_cls;
    logic [7:0]       port_tid;
    logic [7:0]       cmp_vld;
    logic [7:0][2:0]  cmp_idx;
    logic [7:0]       cmp_tid;

    uop_port_dispatch #(.AGE_W(AGE_W), .FMA_LAT(FMA_LAT), .LD_LAT(LD_LAT)) u_dut (
        .clk(clk), .rst(rst), .win_vld(win_vld), .win_cls(win_cls),
        .win_tid(win_tid), .win_age(win_age), .grant(grant),
        .port_en(port_en), .port_idx(port_idx), .port_cls(port_cls),
        .port_tid(port_tid), .cmp_vld(cmp_vld), .cmp_idx(cmp_idx), .cmp_tid(cmp_tid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // bench copy of the window
    bit bv[8];
    int bc[8];
    bit bt[8];
    int bseq[8];
    int seq_ctr = 0;
    // expected completion schedule, ring indexed by cycle
    bit sv[8][16];
    bit sf[8][16];
    int si[8][16];
    bit st[8][16];
    // expected port outputs from the latest decision
    bit ev[8];
    int ei[8];
    int ec[8];
    bit et[8];
    int cyc = 0;
    logic [7:0] last_grant;
    int unsigned rs = 32'h1234_5678;
    int ORDER[8] = '{7, 4, 2, 3, 6, 0, 1, 5};

    function automatic int unsigned rnd();
        rs = rs * 32'd1103515245 + 32'd12345;
        return rs >> 16;
    endfunction

    function automatic bit m_cap(int p, int c);
        case (p)
            0: return c == 0 || c == 1 || c == 2;
            1: return c == 0 || c == 2;
            2, 3: return c == 3 || c == 4;
            4: return c == 5;
            5: return c == 0;
            6: return c == 0 || c == 1;
            default: return c == 4;
        endcase
    endfunction

    function automatic int m_lat(int c);
        if (c == 2) return FMA_LAT;
        if (c == 3) return LD_LAT;
        return 1;
    endfunction

    function automatic bit m_ok(int p, int c);
        for (int d = 1; d < FMA_LAT; d++)
            if (sv[p][(cyc + d) % 16] && sf[p][(cyc + d) % 16]) return 1'b0;
        if (sv[p][(cyc + m_lat(c)) % 16]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic clear_model();
        for (int p = 0; p < 8; p++) begin
            ev[p] = 0;
            for (int k = 0; k < 16; k++) sv[p][k] = 0;
        end
    endtask

    task automatic clear_window();
        for (int i = 0; i < 8; i++) bv[i] = 0;
    endtask

    task automatic put(int i, int c, bit t);
        bv[i] = 1; bc[i] = c; bt[i] = t; bseq[i] = seq_ctr; seq_ctr++;
    endtask

    task automatic drive();
        for (int i = 0; i < 8; i++) begin
            int r;
            r = 0;
            for (int j = 0; j < 8; j++) if (bv[j] && bv[i] && bseq[j] < bseq[i]) r++;
            win_vld[i] = bv[i];
            win_cls[i] = 3'(bc[i]);
            win_tid[i] = bt[i];
            win_age[i] = AGE_W'(r);
        end
    endtask

    task automatic decide(output logic [7:0] expg);
        bit tk[8];
        for (int i = 0; i < 8; i++) tk[i] = 0;
        for (int s = 0; s < 8; s++) begin
            int p, best, bp;
            p = ORDER[s]; best = -1; bp = -1;
            for (int i = 0; i < 8; i++) begin
                if (bv[i] && !tk[i] && m_cap(p, bc[i]) && m_ok(p, bc[i])) begin
                    if (best < 0 || bseq[i] < bseq[best]) best = i;
                    if (p == 6 && bc[i] == 1 && (bp < 0 || bseq[i] < bseq[bp])) bp = i;
                end
            end
            if (bp >= 0) best = bp;
            ev[p] = (best >= 0);
            if (best >= 0) begin
                ei[p] = best; ec[p] = bc[best]; et[p] = bt[best]; tk[best] = 1;
            end
        end
        for (int i = 0; i < 8; i++) expg[i] = tk[i];
    endtask

    // one cycle: called at a falling edge, returns at the next falling edge
    task automatic step();
        logic [7:0] expg;
        int nexp;
        for (int p = 0; p < 8; p++) begin
            chk(port_en[p] == ev[p], "R9", $sformatf("port_en[%0d]", p), port_en[p], ev[p]);
            if (ev[p]) begin
                chk(port_idx[p] == 3'(ei[p]), "R9", $sformatf("port_idx[%0d]", p), port_idx[p], ei[p]);
                chk(port_cls[p] == 3'(ec[p]), "R2", $sformatf("port_cls[%0d]", p), port_cls[p], ec[p]);
                chk(port_tid[p] == et[p], "R11", $sformatf("port_tid[%0d]", p), port_tid[p], et[p]);
            end
            chk(cmp_vld[p] == sv[p][cyc % 16], "R7", $sformatf("cmp_vld[%0d]", p), cmp_vld[p], sv[p][cyc % 16]);
            if (sv[p][cyc % 16]) begin
                chk(cmp_idx[p] == 3'(si[p][cyc % 16]), "R7", $sformatf("cmp_idx[%0d]", p), cmp_idx[p], si[p][cyc % 16]);
                chk(cmp_tid[p] == st[p][cyc % 16], "R11", $sformatf("cmp_tid[%0d]", p), cmp_tid[p], st[p][cyc % 16]);
            end
            sv[p][cyc % 16] = 0;
        end
        drive();
        #1;
        decide(expg);
        last_grant = grant;
        chk(grant == expg, "R3", "grant vector", grant, expg);
        chk((grant & ~win_vld) == 0, "R1", "grant outside valid", grant, 0);
        nexp = 0;
        for (int p = 0; p < 8; p++) if (ev[p]) nexp++;
        chk($countones(grant) == nexp, "R1", "grant count", $countones(grant), nexp);
        for (int p = 0; p < 8; p++) begin
            if (ev[p]) begin
                int sl;
                sl = (cyc + m_lat(ec[p])) % 16;
                sv[p][sl] = 1; sf[p][sl] = (ec[p] == 2); si[p][sl] = ei[p]; st[p][sl] = et[p];
                bv[ei[p]] = 0;
            end
        end
        @(posedge clk);
        cyc++;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        clear_window();
        drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        clear_model();
        chk(port_en == 8'h00, "R10", "port_en after reset", port_en, 0);
        chk(cmp_vld == 8'h00, "R10", "cmp_vld after reset", cmp_vld, 0);
    endtask

    task automatic drain(int n);
        clear_window();
        repeat (n) step();
    endtask

    task automatic fill(int mode, int density);
        for (int i = 0; i < 8; i++) begin
            if (!bv[i] && (rnd() % 100) < density) begin
                int c;
                case (mode)
                    1: c = (rnd() % 3 == 0) ? 0 : 1;
                    2: c = (rnd() % 4 == 0) ? 0 : 2;
                    3: c = 3 + int'(rnd() % 3);
                    default: c = int'(rnd() % 6);
                endcase
                put(i, c, bit'(rnd() & 1));
            end
        end
    endtask

    localparam int LONE_PORT[6] = '{6, 6, 0, 2, 7, 4};

    initial begin
        #(CLK_PERIOD * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_model();
        clear_window();
        @(negedge clk);
        do_reset();
        #1;
        chk(grant == 8'h00, "R10", "grant with empty window", grant, 0);

        // R2: a lone micro-op of each class at each slot lands on its first port
        for (int c = 0; c < 6; c++) begin
            for (int i = 0; i < 8; i++) begin
                clear_window();
                put(i, c, bit'(i & 1));
                step();
                chk(port_en[LONE_PORT[c]] == 1'b1, "R2", $sformatf("lone class %0d port", c), port_en, LONE_PORT[c]);
                chk(port_idx[LONE_PORT[c]] == 3'(i), "R2", "lone index", port_idx[LONE_PORT[c]], i);
                drain(6);
            end
        end

        // R4: two branches split between ports 6 and 0
        clear_window();
        put(3, 1, 0); put(5, 1, 1); put(0, 0, 0); put(7, 2, 1);
        step();
        chk(port_en[6] && port_idx[6] == 3'd3, "R4", "older branch on port 6", port_idx[6], 3);
        chk(port_en[0] && port_idx[0] == 3'd5, "R4", "second branch on port 0", port_idx[0], 5);
        chk(port_en[1] && port_idx[1] == 3'd0, "R3", "ALU older than FMA on port 1", port_idx[1], 0);
        drain(7);

        // R5: store addresses take port 7, then port 2; a load gets port 3
        clear_window();
        put(0, 4, 0); put(1, 4, 0); put(2, 3, 1); put(3, 3, 1);
        step();
        chk(port_en[7] && port_idx[7] == 3'd0, "R5", "store address on port 7", port_idx[7], 0);
        chk(port_en[2] && port_idx[2] == 3'd1, "R5", "store address falls to port 2", port_idx[2], 1);
        chk(port_en[3] && port_idx[3] == 3'd2, "R5", "load on port 3", port_idx[3], 2);
        drain(7);

        // R6: two FMAs occupy ports 0 and 1; a third waits FMA_LAT-1 cycles
        clear_window();
        put(0, 2, 0); put(1, 2, 1);
        step();
        chk(last_grant == 8'h03, "R6", "two FMAs granted", last_grant, 3);
        put(2, 2, 0);
        for (int k = 1; k < FMA_LAT; k++) begin
            step();
            chk(last_grant == 8'h00, "R6", $sformatf("FMA held cycle %0d", k), last_grant, 0);
        end
        step();
        chk(last_grant == 8'h04, "R6", "FMA released", last_grant, 4);
        drain(7);

        // R8: a load on port 2 blocks a store address completing in the same cycle
        clear_window();
        put(0, 3, 0);
        step();
        step();
        step();
        put(1, 4, 0); put(2, 4, 1); put(3, 4, 0);
        step();
        chk(last_grant == 8'h06, "R8", "port 2 write slot taken", last_grant, 6);
        chk(port_en[2] == 1'b0 && port_en[3] == 1'b1, "R8", "port 3 used instead of port 2", port_en, 8);
        drain(7);

        // R11: threads compete only by age
        clear_window();
        put(5, 0, 1); put(1, 0, 0);
        step();
        chk(port_en[6] && port_idx[6] == 3'd5 && port_tid[6] == 1'b1, "R11", "older thread-1 ALU on port 6", port_idx[6], 5);
        chk(port_en[0] && port_tid[0] == 1'b0, "R11", "thread-0 ALU on port 0", port_tid[0], 0);
        drain(7);

        // mixed sweeps over class mixes and fill densities
        for (int mode = 0; mode < 4; mode++) begin
            for (int n = 0; n < 400; n++) begin
                fill(mode, (n % 50 < 10) ? 20 : 70);
                step();
            end
            if (mode == 1) begin
                fill(2, 100);
                step();
                step();
                do_reset();
            end
        end
        drain(8);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule